// File: doc/BRIEF.md
# Inter-Hart Message Mailbox

This block gives a group of hardware threads a direct way to hand short messages to one another. Every hart has a receive queue of its own. A hart posts a word by naming a target hart. The word, tagged with the index of the sending hart, goes into the target's queue. A hart reads its own queue with a load request, which returns the oldest word together with the index of the hart that sent it. A hart can also clear its own queue at any time. While a queue holds anything, the interrupt line of its owner stays high.

All requests are answered within the cycle in which they are presented. The send, load and flush inputs are sampled together. Queue state changes at the next rising clock edge. Several harts may aim at the same target in one cycle. In that case the lowest-numbered sender is served and the others are told to retry. A refusal because a queue is full, and a load from an empty queue, are reported as faults. The owning processor can turn these faults into exceptions. A hart may post to itself.

Top module: `hart_mailbox`

## Requirements
- R1: After reset every queue is empty: all `irq` bits are 0 and a load from any hart reports `ld_empty`.
- R2: A granted send to a target with room answers `snd_ok`. Loads then return the target's words oldest first, with the data on `ld_data` and the sender's index on `ld_src`, and assert `ld_ok`.
- R3: A granted send to a target that holds DEPTH words, with no pop and no flush on that target in the same cycle, answers `snd_full` and stores nothing. A target index of HARTS or above is also answered with `snd_full`.
- R4: A load on an empty queue asserts `ld_empty`, not `ld_ok`, and leaves the queue unchanged.
- R5: A flush request clears only the requesting hart's queue. Other queues keep their contents.
- R6: `irq[h]` is 1 exactly when the queue of hart h holds at least one word.
- R7: When several harts post to the same target in one cycle, only the lowest-numbered one is granted. Each of the others gets `snd_busy`, and its word is not stored.
- R8: A flush and a granted send on the same queue in one cycle act as flush then enqueue. Afterwards the queue holds only the new word.
- R9: A load and a granted send on the same queue in one cycle both succeed, even when that queue is full.
- R10: A hart may post to its own queue, with the same result as posting to any other hart.
- R11: Each sender with a request gets exactly one of `snd_ok`, `snd_full` or `snd_busy` in the request cycle, and a hart without a request gets none of them. Each load request gets exactly one of `ld_ok` or `ld_empty`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| snd_req | input | HARTS | Per-hart send request |
| snd_tgt | input | HARTS*IW | Per-hart target index; slot s is bits [s*IW +: IW] |
| snd_data | input | HARTS*DW | Per-hart message word; slot s is bits [s*DW +: DW] |
| snd_ok | output | HARTS | Send accepted |
| snd_full | output | HARTS | Send refused: target queue full or target out of range |
| snd_busy | output | HARTS | Send lost arbitration; retry |
| ld_req | input | HARTS | Per-hart pop request on its own queue |
| ld_ok | output | HARTS | Pop performed; ld_data and ld_src valid |
| ld_empty | output | HARTS | Pop refused: queue empty |
| ld_data | output | HARTS*DW | Popped word per hart |
| ld_src | output | HARTS*IW | Index of the hart that sent the popped word |
| flush | input | HARTS | Per-hart clear of its own queue |
| irq | output | HARTS | Per-hart level interrupt: queue not empty |

## Verification
The bench targets the same-cycle collisions. These are a full queue that is popped while a send arrives, a flush that coincides with an arriving word, and three senders contending for one target that is itself full. If pop and send were ordered the wrong way, the bench would see a spurious `snd_full`. If the flush were applied after the enqueue, the new word would be lost and `irq` would drop. If the arbitration were wrong, a higher-numbered hart would win or a loser would be told `snd_full`. Loads on empty queues are followed by a send and a load, which shows that no read pointer moved. Flushes are checked against the untouched queues of the other harts. Long random traffic then compares every word and source index against a queue model.

// File: rtl/hart_mailbox.sv
module hart_mailbox #(
  parameter int HARTS = 4,
  parameter int DEPTH = 4,
  parameter int DW    = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [HARTS-1:0]              snd_req,
  input  logic [HARTS*$clog2(HARTS)-1:0] snd_tgt,
  input  logic [HARTS*DW-1:0]           snd_data,
  output logic [HARTS-1:0]              snd_ok,
  output logic [HARTS-1:0]              snd_full,
  output logic [HARTS-1:0]              snd_busy,
  input  logic [HARTS-1:0]              ld_req,
  output logic [HARTS-1:0]              ld_ok,
  output logic [HARTS-1:0]              ld_empty,
  output logic [HARTS*DW-1:0]           ld_data,
  output logic [HARTS*$clog2(HARTS)-1:0] ld_src,
  input  logic [HARTS-1:0]              flush,
  output logic [HARTS-1:0]              irq
);
  localparam int IW = $clog2(HARTS);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam int EW = IW + DW;

  logic [HARTS-1:0] win_vld, room, push;
  logic [IW-1:0]    win_src [HARTS];

  always_comb begin
    for (int t = 0; t < HARTS; t++) begin
      win_vld[t] = 1'b0;
      win_src[t] = '0;
      for (int s = HARTS - 1; s >= 0; s--) begin
        if (snd_req[s] && snd_tgt[s*IW +: IW] == IW'(t)) begin
          win_vld[t] = 1'b1;
          win_src[t] = IW'(s);
        end
      end
    end
  end

  always_comb begin
    for (int s = 0; s < HARTS; s++) begin
      snd_ok[s]   = 1'b0;
      snd_full[s] = snd_req[s];
      snd_busy[s] = 1'b0;
      for (int t = 0; t < HARTS; t++) begin
        if (snd_req[s] && snd_tgt[s*IW +: IW] == IW'(t)) begin
          snd_full[s] = (win_src[t] == IW'(s)) && !room[t];
          snd_ok[s]   = (win_src[t] == IW'(s)) &&  room[t];
          snd_busy[s] = (win_src[t] != IW'(s));
        end
      end
    end
  end

  for (genvar h = 0; h < HARTS; h++) begin : g_q
    logic [EW-1:0] mem [DEPTH];
    logic [AW-1:0] rp, wp;
    logic [CW-1:0] cnt;
    logic          empty, pop;
    logic [EW-1:0] head, wdat;

    assign empty   = (cnt == '0);
    assign pop     = ld_req[h] && !empty;
    assign room[h] = (cnt != CW'(DEPTH)) || pop || flush[h];
    assign push[h] = win_vld[h] && room[h];
    assign head    = mem[rp];
    assign wdat    = {win_src[h], snd_data[win_src[h]*DW +: DW]};

    assign ld_ok[h]               = pop;
    assign ld_empty[h]            = ld_req[h] && empty;
    assign ld_data[h*DW +: DW]    = pop ? head[DW-1:0] : '0;
    assign ld_src[h*IW +: IW]     = pop ? head[EW-1:DW] : '0;
    assign irq[h]                 = !empty;

    always_ff @(posedge clk) begin
      if (push[h]) mem[wp] <= wdat;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rp  <= '0;
        wp  <= '0;
        cnt <= '0;
      end else begin
        wp <= wp + AW'(push[h]);
        if (flush[h]) begin
          rp  <= wp;
          cnt <= CW'(push[h]);
        end else begin
          rp  <= rp + AW'(pop);
          cnt <= cnt + CW'(push[h]) - CW'(pop);
        end
      end
    end
  end
endmodule

// File: rtl/hart_mailbox_chk.sv
module hart_mailbox_chk #(
  parameter int HARTS = 4,
  parameter int IW    = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [HARTS-1:0]      snd_req,
  input logic [HARTS*IW-1:0]   snd_tgt,
  input logic [HARTS-1:0]      snd_ok,
  input logic [HARTS-1:0]      snd_full,
  input logic [HARTS-1:0]      snd_busy,
  input logic [HARTS-1:0]      ld_req,
  input logic [HARTS-1:0]      ld_ok,
  input logic [HARTS-1:0]      ld_empty,
  input logic [HARTS-1:0]      flush,
  input logic [HARTS-1:0]      irq
);
  logic [HARTS-1:0] arrive;
  int               arr_n [HARTS];

  always_comb begin
    for (int t = 0; t < HARTS; t++) begin
      arr_n[t] = 0;
      for (int s = 0; s < HARTS; s++)
        if (snd_ok[s] && snd_tgt[s*IW +: IW] == IW'(t)) arr_n[t]++;
      arrive[t] = (arr_n[t] != 0);
    end
  end

  for (genvar h = 0; h < HARTS; h++) begin : g_a
    a_r11_one_resp: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({snd_ok[h], snd_full[h], snd_busy[h]}) == 32'(snd_req[h]));
    a_r11_one_ld: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({ld_ok[h], ld_empty[h]}) == 32'(ld_req[h]));
    a_r4_empty_load: assert property (@(posedge clk) disable iff (!rst_n)
      ld_req[h] && !irq[h] |-> ld_empty[h]);
    a_r6_irq_load: assert property (@(posedge clk) disable iff (!rst_n)
      ld_req[h] && irq[h] |-> ld_ok[h]);
    a_r5_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
      flush[h] && !arrive[h] |=> !irq[h]);
    a_r8_flush_keeps_new: assert property (@(posedge clk) disable iff (!rst_n)
      flush[h] && arrive[h] |=> irq[h]);
    a_r7_one_winner: assert property (@(posedge clk) disable iff (!rst_n)
      arr_n[h] <= 1);
  end
endmodule

bind hart_mailbox hart_mailbox_chk #(.HARTS(HARTS), .IW($clog2(HARTS))) u_chk (
  .clk(clk), .rst_n(rst_n), .snd_req(snd_req), .snd_tgt(snd_tgt),
  .snd_ok(snd_ok), .snd_full(snd_full), .snd_busy(snd_busy),
  .ld_req(ld_req), .ld_ok(ld_ok), .ld_empty(ld_empty),
  .flush(flush), .irq(irq)
);

// File: tb/tb_hart_mailbox.sv
`timescale 1ns/1ps
module tb_hart_mailbox;
  localparam int H  = 4;
  localparam int D  = 4;
  localparam int DW = 16;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [H-1:0]    snd_req = '0, ld_req = '0, flush = '0;
  logic [H*IW-1:0] snd_tgt = '0;
  logic [H*DW-1:0] snd_data = '0;
  logic [H-1:0]    snd_ok, snd_full, snd_busy, ld_ok, ld_empty, irq;
  logic [H*DW-1:0] ld_data;
  logic [H*IW-1:0] ld_src;

  int nchk = 0, nfail = 0;
  bit done = 1'b0;
  logic [IW+DW-1:0] mq [H][$];

  always #4 clk = ~clk;

  hart_mailbox #(.HARTS(H), .DEPTH(D), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .snd_req(snd_req), .snd_tgt(snd_tgt),
    .snd_data(snd_data), .snd_ok(snd_ok), .snd_full(snd_full),
    .snd_busy(snd_busy), .ld_req(ld_req), .ld_ok(ld_ok),
    .ld_empty(ld_empty), .ld_data(ld_data), .ld_src(ld_src),
    .flush(flush), .irq(irq)
  );

  task automatic chk(bit good, string r, string sc, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (!good) begin
      nfail++;
      $display("FAIL %s (%s): actual %0h expected %0h", r, sc, act, exp);
    end
  endtask

  // driver + scoreboard: drive one cycle, compare against the queue model, then update it
  task automatic step(input logic [H-1:0] sr, input logic [H*IW-1:0] st,
                      input logic [H*DW-1:0] sd, input logic [H-1:0] lr,
                      input logic [H-1:0] fl, input string sc);
    int sz [H];
    bit rm [H];
    bit wv [H];
    int ws [H];
    @(negedge clk);
    snd_req = sr; snd_tgt = st; snd_data = sd; ld_req = lr; flush = fl;
    #3;
    for (int h = 0; h < H; h++) begin
      sz[h] = mq[h].size();
      chk(irq[h] == (sz[h] > 0), "R6", sc, irq[h], sz[h] > 0);
      if (lr[h] && sz[h] > 0) begin
        chk(ld_ok[h] && !ld_empty[h], "R2", sc, {ld_ok[h], ld_empty[h]}, 2'b10);
        chk(ld_data[h*DW +: DW] == mq[h][0][DW-1:0], "R2", sc, ld_data[h*DW +: DW], mq[h][0][DW-1:0]);
        chk(ld_src[h*IW +: IW] == mq[h][0][IW+DW-1:DW], "R2", sc, ld_src[h*IW +: IW], mq[h][0][IW+DW-1:DW]);
      end else if (lr[h]) begin
        chk(!ld_ok[h] && ld_empty[h], "R4", sc, {ld_ok[h], ld_empty[h]}, 2'b01);
      end else begin
        chk(!ld_ok[h] && !ld_empty[h], "R11", sc, {ld_ok[h], ld_empty[h]}, 2'b00);
      end
      rm[h] = (sz[h] < D) || (lr[h] && sz[h] > 0) || fl[h];
      wv[h] = 1'b0; ws[h] = 0;
    end
    for (int t = 0; t < H; t++)
      for (int s = H - 1; s >= 0; s--)
        if (sr[s] && st[s*IW +: IW] == IW'(t)) begin wv[t] = 1'b1; ws[t] = s; end
    for (int s = 0; s < H; s++) begin
      int t;
      logic [2:0] e;
      string r;
      t = int'(st[s*IW +: IW]);
      e = !sr[s] ? 3'b000 : (ws[t] != s) ? 3'b001 : rm[t] ? 3'b100 : 3'b010;
      r = !sr[s] ? "R11" : e[0] ? "R7" : e[1] ? "R3" : "R2";
      chk({snd_ok[s], snd_full[s], snd_busy[s]} == e, r, sc,
          {snd_ok[s], snd_full[s], snd_busy[s]}, e);
    end
    for (int h = 0; h < H; h++) begin
      if (lr[h] && sz[h] > 0) void'(mq[h].pop_front());
      if (fl[h]) mq[h].delete();
    end
    for (int t = 0; t < H; t++)
      if (wv[t] && rm[t]) mq[t].push_back({IW'(ws[t]), sd[ws[t]*DW +: DW]});
  endtask

  task automatic op(int s, int t, logic [DW-1:0] d, logic [H-1:0] lr, logic [H-1:0] fl, string sc);
    logic [H-1:0] sr = '0;
    logic [H*IW-1:0] st = '0;
    logic [H*DW-1:0] sd = '0;
    if (s >= 0) begin
      sr[s] = 1'b1; st[s*IW +: IW] = IW'(t); sd[s*DW +: DW] = d;
    end
    step(sr, st, sd, lr, fl, sc);
  endtask

  task automatic ld(int h, string sc);
    op(-1, 0, '0, H'(1) << h, '0, sc);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [H-1:0] sr;
    logic [H*IW-1:0] st;
    logic [H*DW-1:0] sd;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state
    op(-1, 0, '0, '0, '0, "R1 idle");
    op(-1, 0, '0, '1, '0, "R1 load all");

    // R2: order and source index
    op(1, 2, 16'hA001, '0, '0, "R2 a");
    op(1, 2, 16'hA002, '0, '0, "R2 b");
    op(3, 2, 16'hB003, '0, '0, "R2 c");
    ld(2, "R2 pop"); ld(2, "R2 pop"); ld(2, "R2 pop"); ld(2, "R2 drained");

    // R10: self send
    op(0, 0, 16'h5E1F, '0, '0, "R10 self");
    ld(0, "R10 pop");

    // R3: full target refuses and stores nothing
    for (int i = 0; i < D; i++) op(0, 3, 16'hC000 + 16'(i), '0, '0, "R3 fill");
    op(2, 3, 16'hDEAD, '0, '0, "R3 overflow");
    for (int i = 0; i <= D; i++) ld(3, "R3 drain");

    // R4: empty load changes nothing
    ld(1, "R4 empty"); ld(1, "R4 empty");
    op(2, 1, 16'h0404, '0, '0, "R4 after");
    ld(1, "R4 first word"); ld(1, "R4 empty again");

    // R5: flush only own queue
    op(0, 1, 16'h5101, '0, '0, "R5 q1");
    op(3, 1, 16'h5102, '0, '0, "R5 q1");
    op(0, 2, 16'h5201, '0, '0, "R5 q2");
    op(-1, 0, '0, '0, 4'b0010, "R5 flush1");
    op(-1, 0, '0, '0, '0, "R5 check irq");
    ld(1, "R5 flushed"); ld(2, "R5 kept");

    // R7: contention, lowest wins; then retry
    sr = 4'b1011; st = {2'd2, 2'd0, 2'd2, 2'd2};
    sd = {16'h7003, 16'h0, 16'h7001, 16'h7000};
    step(sr, st, sd, '0, '0, "R7 three to one");
    sr = 4'b1010; step(sr, st, sd, '0, '0, "R7 retry");
    sr = 4'b1000; step(sr, st, sd, '0, '0, "R7 retry");
    ld(2, "R7 pop"); ld(2, "R7 pop"); ld(2, "R7 pop"); ld(2, "R7 empty");
    // R7 with full target: winner sees full, losers busy
    for (int i = 0; i < D; i++) op(2, 1, 16'h7100 + 16'(i), '0, '0, "R7 fill");
    sr = 4'b1101; st = {2'd1, 2'd1, 2'd0, 2'd1};
    sd = {16'h7F3, 16'h7F2, 16'h0, 16'h7F0};
    step(sr, st, sd, '0, '0, "R7 full target");
    op(-1, 0, '0, '0, 4'b0010, "R7 clear");

    // R8: flush + arriving word
    op(1, 0, 16'h8001, '0, '0, "R8 pre");
    op(2, 0, 16'h8002, '0, '0, "R8 pre");
    op(3, 0, 16'h8888, '0, 4'b0001, "R8 flush+send");
    ld(0, "R8 survivor"); ld(0, "R8 empty");

    // R9: send and load on a full queue
    for (int i = 0; i < D; i++) op(0, 3, 16'h9000 + 16'(i), '0, '0, "R9 fill");
    op(1, 3, 16'h9999, 4'b1000, '0, "R9 pop+send");
    for (int i = 0; i <= D; i++) ld(3, "R9 drain");

    // mixed random traffic against the model
    for (int i = 0; i < 600; i++) begin
      logic [H-1:0] lr, fl;
      sr = H'($urandom);
      st = (H*IW)'($urandom);
      sd = {$urandom, $urandom};
      lr = H'($urandom) & H'($urandom);
      fl = ($urandom % 10 == 0) ? H'(1) << ($urandom % H) : '0;
      step(sr, st, sd, lr, fl, "R2 random");
    end
    for (int i = 0; i < D + 1; i++) op(-1, 0, '0, '1, '0, "R6 final drain");
    op(-1, 0, '0, '0, '0, "R6 idle");
    finish_run();
  end
endmodule